// File: doc/BRIEF.md
# Interrupt Selection and Status-Word Swapper

This block decides which interrupt a processor core takes next and performs the full exchange of the processor status word. Each status word is a 64-bit mask plus a 64-bit instruction address. When the core strobes `start`, the block picks the interruption to take. Two kinds arrive with the strobe: a program exception or a supervisor call. The external class has three internal sources: a LIFO stack of queued external requests, a time-of-day comparator flag and a CPU-timer flag. The two timer flags are set by single-cycle event pulses.

Once a class is chosen, the block writes three 64-bit words to that class's fixed slot in low memory. These are an information word (interruption code plus instruction length or parameter), the old mask with the live condition code merged in, and the old address. It then reads the class's new mask and new address from the same slot and installs them as the current status word. If the loaded word is a wait state, the block enters a halted state. If that wait state also masks every interrupt class, the block requests a halt of the whole machine.

The current status word can also be written directly while the block is idle. The current condition code comes in on its own input.

Top module: `intr_swapper`

## Requirements
- R1: External sources are considered only when `start` has `exc_kind` = none (0 or 1) and bit 56 (external mask) of the current mask is 1. Otherwise, with no program or supervisor-call request, `done` pulses with `done_cls` = 0 (none) and no memory transfer is made.
- R2: A program request (`exc_kind` = 2) or supervisor call (`exc_kind` = 3) always wins. Among external sources the order is fixed: queued entry first, then the time-of-day flag, then the CPU-timer flag. `done_cls` is 1 for external, 2 for program and 3 for supervisor call.
- R3: A time-of-day interrupt stores code 0x1004 and a CPU-timer interrupt stores code 0x1005, each with a zero parameter. Taking either clears the time-of-day flag, and taking the CPU timer also clears its own flag. A fire pulse in the same cycle as a clear leaves the flag set.
- R4: The stored old mask equals the current mask with bits 14:13 replaced by `cc_in`. `cc_out` always shows bits 14:13 of the current mask, so after a swap it shows the loaded word's bits.
- R5: For a supervisor call, the information word holds the code in bits 15:0 and the length in bits 19:16, and the stored old address is the current address plus `exc_ilen`.
- R6: For a program interrupt, the information word has the same layout as R5 and the stored old address is the current address, unchanged.
- R7: Queued external entries are delivered last-in first-out. The external information word carries the code in bits 15:0 and the parameter in bits 63:32. A push into a full stack (after any same-cycle pop) is dropped, and `ext_err` pulses one cycle later.
- R8: After a load, `halted` equals bit 49 (wait) of the new mask and stays until the next accepted `start`, which clears it. `halt_req` pulses together with `done` when the wait bit is 1 and bits 57 (I/O), 56 (external) and 50 (machine check) are all 0.
- R9: A swap makes five word transfers at slot base + 0..4: write info, write old mask, write old address, read new mask, read new address. Word-address slot bases are external 0x010, supervisor call 0x020 and program 0x030. A transfer completes only in a cycle with `mem_valid` and `mem_ready`, and holds its address, direction and data until then.
- R10: `done` pulses for one cycle, in the cycle after the fifth transfer completes. In that same cycle the new mask and address are visible on `psw_mask` and `psw_addr`.
- R11: `psw_wr` loads the current status word on the next edge when the block is idle, and is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_fire | input | 1 | Time-of-day comparator event, sets its flag |
| cpt_fire | input | 1 | CPU-timer event, sets its flag |
| ext_push | input | 1 | Push an external request onto the stack |
| ext_push_code | input | 16 | Code of the pushed external request |
| ext_push_parm | input | 32 | Parameter of the pushed external request |
| start | input | 1 | Request an interrupt decision and swap |
| exc_kind | input | 2 | 2 = program, 3 = supervisor call, else none |
| exc_code | input | 16 | Program or supervisor-call code |
| exc_ilen | input | 4 | Instruction length in bytes |
| cc_in | input | 2 | Live condition code |
| psw_wr | input | 1 | Direct write of the current status word |
| psw_wr_mask | input | 64 | Mask for the direct write |
| psw_wr_addr | input | 64 | Address for the direct write |
| psw_mask | output | 64 | Current status-word mask |
| psw_addr | output | 64 | Current status-word address |
| cc_out | output | 2 | Condition code from mask bits 14:13 |
| busy | output | 1 | Swap in progress |
| done | output | 1 | One-cycle completion pulse |
| done_cls | output | 2 | Class taken, valid with `done` |
| halted | output | 1 | Wait state loaded |
| halt_req | output | 1 | Wait state with all classes masked |
| ext_err | output | 1 | External stack overrun pulse |
| mem_valid | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Transfer accepted; read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
The first memory request is visible in the cycle after `start` is accepted. Each further transfer follows the cycle after the previous one completes, so `mem_ready` stalls delay the whole sequence cycle by cycle. `done`, `done_cls`, the new status word, `halted` and `halt_req` all change one edge after the fifth transfer completes, or one edge after `start` when nothing is taken. `ext_err` follows the overflowing push by one edge, and a timer flag set by a pulse is first seen by a `start` one edge later. The bench moves its reference model across each rising edge using the inputs it applied, then compares every output on the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/swp_pkg.sv
`timescale 1ns/1ps
package swp_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_EXT  = 2'd1,
        CLS_PGM  = 2'd2,
        CLS_SVC  = 2'd3
    } cls_e;

    // status-word mask bit positions
    localparam int CC_LO    = 13;
    localparam int WAIT_BIT = 49;
    localparam int MCK_BIT  = 50;
    localparam int EXT_BIT  = 56;
    localparam int IO_BIT   = 57;

    localparam logic [15:0] CODE_TOD = 16'h1004;
    localparam logic [15:0] CODE_CPT = 16'h1005;

    // transfer steps inside a slot
    localparam logic [2:0] STEP_INFO  = 3'd0;
    localparam logic [2:0] STEP_OMASK = 3'd1;
    localparam logic [2:0] STEP_OADDR = 3'd2;
    localparam logic [2:0] STEP_NMASK = 3'd3;
    localparam logic [2:0] STEP_NADDR = 3'd4;

    typedef struct packed {
        cls_e        cls;
        logic [63:0] info;
        logic [63:0] omask;
        logic [63:0] oaddr;
    } swap_t;

    function automatic logic [63:0] merge_cc(input logic [63:0] mask, input logic [1:0] cc);
        logic [63:0] m;
        m = mask;
        m[CC_LO +: 2] = cc;
        return m;
    endfunction

    function automatic logic [63:0] info_ext(input logic [15:0] code, input logic [31:0] parm);
        return {parm, 16'h0000, code};
    endfunction

    function automatic logic [63:0] info_exc(input logic [15:0] code, input logic [3:0] ilen);
        return {44'h0, ilen, code};
    endfunction

endpackage

// File: rtl/swp_extq.sv
`timescale 1ns/1ps
module swp_extq #(
    parameter int DEPTH = 4,
    parameter int CW    = 16,
    parameter int PW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [CW-1:0] push_code,
    input  logic [PW-1:0] push_parm,
    input  logic          pop,
    output logic [CW-1:0] top_code,
    output logic [PW-1:0] top_parm,
    output logic          nonempty,
    output logic          overrun
);
    localparam int IW    = $clog2(DEPTH + 1);
    localparam int SLOTS = 1 << IW;

    logic [IW-1:0] cnt;
    logic [IW-1:0] lvl;
    logic [IW-1:0] top_idx;
    logic          pop_ok;
    logic          push_ok;
    logic [CW-1:0] code_q [SLOTS];
    logic [PW-1:0] parm_q [SLOTS];

    assign nonempty = (cnt != '0);
    assign pop_ok   = pop && nonempty;
    assign lvl      = cnt - IW'(pop_ok);
    assign push_ok  = push && (lvl < IW'(DEPTH));
    assign top_idx  = cnt - IW'(1);
    assign top_code = nonempty ? code_q[top_idx] : '0;
    assign top_parm = nonempty ? parm_q[top_idx] : '0;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[g] <= '0;
                parm_q[g] <= '0;
            end else if (push_ok && (lvl == IW'(g))) begin
                code_q[g] <= push_code;
                parm_q[g] <= push_parm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            cnt     <= lvl + IW'(push_ok);
            overrun <= push && !push_ok;
        end
    end
endmodule

// File: rtl/swp_arb.sv
`timescale 1ns/1ps
module swp_arb
    import swp_pkg::*;
(
    input  logic [1:0]  exc_kind,
    input  logic [15:0] exc_code,
    input  logic [3:0]  exc_ilen,
    input  logic [63:0] cur_mask,
    input  logic [63:0] cur_addr,
    input  logic [1:0]  cc_in,
    input  logic        q_nonempty,
    input  logic [15:0] q_code,
    input  logic [31:0] q_parm,
    input  logic        tod_p,
    input  logic        cpt_p,
    output swap_t       sel,
    output logic        pop_req,
    output logic        clr_tod,
    output logic        clr_cpt
);
    always_comb begin
        sel.cls   = CLS_NONE;
        sel.info  = '0;
        sel.omask = merge_cc(cur_mask, cc_in);
        sel.oaddr = cur_addr;
        pop_req   = 1'b0;
        clr_tod   = 1'b0;
        clr_cpt   = 1'b0;
        if (cls_e'(exc_kind) == CLS_PGM) begin
            sel.cls  = CLS_PGM;
            sel.info = info_exc(exc_code, exc_ilen);
        end else if (cls_e'(exc_kind) == CLS_SVC) begin
            sel.cls   = CLS_SVC;
            sel.info  = info_exc(exc_code, exc_ilen);
            sel.oaddr = cur_addr + 64'(exc_ilen);
        end else if (cur_mask[EXT_BIT]) begin
            if (q_nonempty) begin
                sel.cls  = CLS_EXT;
                sel.info = info_ext(q_code, q_parm);
                pop_req  = 1'b1;
            end else if (tod_p) begin
                sel.cls  = CLS_EXT;
                sel.info = info_ext(CODE_TOD, 32'h0);
                clr_tod  = 1'b1;
            end else if (cpt_p) begin
                sel.cls  = CLS_EXT;
                sel.info = info_ext(CODE_CPT, 32'h0);
                clr_tod  = 1'b1;
                clr_cpt  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/swp_xfer.sv
`timescale 1ns/1ps
module swp_xfer
    import swp_pkg::*;
#(
    parameter int             AW       = 12,
    parameter logic [AW-1:0]  EXT_BASE = AW'(16),
    parameter logic [AW-1:0]  SVC_BASE = AW'(32),
    parameter logic [AW-1:0]  PGM_BASE = AW'(48)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  swap_t         sel,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [63:0]   mem_rdata,
    output logic          busy,
    output logic          load_ev,
    output cls_e          run_cls,
    output logic [63:0]   new_mask,
    output logic [63:0]   new_addr
);
    logic          running;
    logic [2:0]    step;
    swap_t         lat;
    logic [AW-1:0] base;
    logic [AW-1:0] base_n;
    logic [63:0]   nmask;
    logic          fire;

    always_comb begin
        case (sel.cls)
            CLS_EXT: base_n = EXT_BASE;
            CLS_PGM: base_n = PGM_BASE;
            default: base_n = SVC_BASE;
        endcase
    end

    always_comb begin
        case (step)
            STEP_INFO:  mem_wdata = lat.info;
            STEP_OMASK: mem_wdata = lat.omask;
            STEP_OADDR: mem_wdata = lat.oaddr;
            default:    mem_wdata = '0;
        endcase
    end

    assign mem_valid = running;
    assign mem_we    = running && (step < STEP_NMASK);
    assign mem_addr  = base + AW'(step);
    assign fire      = running && mem_ready;
    assign busy      = running;
    assign load_ev   = fire && (step == STEP_NADDR);
    assign run_cls   = lat.cls;
    assign new_mask  = nmask;
    assign new_addr  = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            step    <= '0;
            lat     <= '0;
            base    <= '0;
            nmask   <= '0;
        end else if (!running) begin
            if (take && (sel.cls != CLS_NONE)) begin
                running <= 1'b1;
                step    <= STEP_INFO;
                lat     <= sel;
                base    <= base_n;
            end
        end else if (mem_ready) begin
            if (step == STEP_NMASK) nmask <= mem_rdata;
            if (step == STEP_NADDR) running <= 1'b0;
            else                    step    <= step + 3'd1;
        end
    end
endmodule

// File: rtl/intr_swapper.sv
`timescale 1ns/1ps
module intr_swapper
    import swp_pkg::*;
#(
    parameter int             AW        = 12,
    parameter int             EXT_DEPTH = 4,
    parameter logic [AW-1:0]  EXT_BASE  = AW'(16),
    parameter logic [AW-1:0]  SVC_BASE  = AW'(32),
    parameter logic [AW-1:0]  PGM_BASE  = AW'(48)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tod_fire,
    input  logic          cpt_fire,
    input  logic          ext_push,
    input  logic [15:0]   ext_push_code,
    input  logic [31:0]   ext_push_parm,
    input  logic          start,
    input  logic [1:0]    exc_kind,
    input  logic [15:0]   exc_code,
    input  logic [3:0]    exc_ilen,
    input  logic [1:0]    cc_in,
    input  logic          psw_wr,
    input  logic [63:0]   psw_wr_mask,
    input  logic [63:0]   psw_wr_addr,
    output logic [63:0]   psw_mask,
    output logic [63:0]   psw_addr,
    output logic [1:0]    cc_out,
    output logic          busy,
    output logic          done,
    output logic [1:0]    done_cls,
    output logic          halted,
    output logic          halt_req,
    output logic          ext_err,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [63:0]   mem_rdata
);
    swap_t       sel;
    logic        pop_req, clr_tod, clr_cpt;
    logic        q_nonempty;
    logic [15:0] q_code;
    logic [31:0] q_parm;
    logic        tod_p, cpt_p;
    logic        take;
    logic        load_ev;
    cls_e        run_cls;
    logic [63:0] new_mask, new_addr;
    logic [63:0] mask_r, addr_r;
    logic        all_masked;

    assign take       = start && !busy;
    assign all_masked = !(new_mask[IO_BIT] || new_mask[EXT_BIT] || new_mask[MCK_BIT]);

    swp_extq #(.DEPTH(EXT_DEPTH), .CW(16), .PW(32)) u_extq (
        .clk       (clk),
        .rst       (rst),
        .push      (ext_push),
        .push_code (ext_push_code),
        .push_parm (ext_push_parm),
        .pop       (take && pop_req),
        .top_code  (q_code),
        .top_parm  (q_parm),
        .nonempty  (q_nonempty),
        .overrun   (ext_err)
    );

    swp_arb u_arb (
        .exc_kind   (exc_kind),
        .exc_code   (exc_code),
        .exc_ilen   (exc_ilen),
        .cur_mask   (mask_r),
        .cur_addr   (addr_r),
        .cc_in      (cc_in),
        .q_nonempty (q_nonempty),
        .q_code     (q_code),
        .q_parm     (q_parm),
        .tod_p      (tod_p),
        .cpt_p      (cpt_p),
        .sel        (sel),
        .pop_req    (pop_req),
        .clr_tod    (clr_tod),
        .clr_cpt    (clr_cpt)
    );

    swp_xfer #(.AW(AW), .EXT_BASE(EXT_BASE), .SVC_BASE(SVC_BASE), .PGM_BASE(PGM_BASE)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .sel       (sel),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .load_ev   (load_ev),
        .run_cls   (run_cls),
        .new_mask  (new_mask),
        .new_addr  (new_addr)
    );

    // timer flags: a new event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            tod_p <= 1'b0;
            cpt_p <= 1'b0;
        end else begin
            if (tod_fire)                tod_p <= 1'b1;
            else if (take && clr_tod)    tod_p <= 1'b0;
            if (cpt_fire)                cpt_p <= 1'b1;
            else if (take && clr_cpt)    cpt_p <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_r   <= '0;
            addr_r   <= '0;
            halted   <= 1'b0;
            halt_req <= 1'b0;
            done     <= 1'b0;
            done_cls <= 2'(CLS_NONE);
        end else begin
            done     <= 1'b0;
            halt_req <= 1'b0;
            if (load_ev) begin
                mask_r   <= new_mask;
                addr_r   <= new_addr;
                done     <= 1'b1;
                done_cls <= 2'(run_cls);
                halted   <= new_mask[WAIT_BIT];
                halt_req <= new_mask[WAIT_BIT] && all_masked;
            end else if (psw_wr && !busy) begin
                mask_r <= psw_wr_mask;
                addr_r <= psw_wr_addr;
            end
            if (take) begin
                halted <= 1'b0;
                if (sel.cls == CLS_NONE) begin
                    done     <= 1'b1;
                    done_cls <= 2'(CLS_NONE);
                end
            end
        end
    end

    assign psw_mask = mask_r;
    assign psw_addr = addr_r;
    assign cc_out   = mask_r[CC_LO +: 2];
endmodule

// File: rtl/swp_chk.sv
`timescale 1ns/1ps
module swp_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_push,
    input logic [63:0]   psw_mask,
    input logic [63:0]   psw_addr,
    input logic          busy,
    input logic          done,
    input logic          halted,
    input logic          halt_req,
    input logic          ext_err,
    input logic          mem_valid,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [63:0]   mem_wdata,
    input logic          mem_ready
);
    AST_XFER_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_valid); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_HALT_REQ_PAIRED: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (done && halted)); // R8

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ext_err |-> $past(ext_push)); // R7

    AST_PSW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || ($stable(psw_mask) && $stable(psw_addr)))); // R11
endmodule

bind intr_swapper swp_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_push  (ext_push),
    .psw_mask  (psw_mask),
    .psw_addr  (psw_addr),
    .busy      (busy),
    .done      (done),
    .halted    (halted),
    .halt_req  (halt_req),
    .ext_err   (ext_err),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/tb_intr_swapper.sv
`timescale 1ns/1ps
module tb_intr_swapper;
    localparam int DEPTH = 4;
    localparam logic [63:0] M_EXT  = 64'h1 << 56;
    localparam logic [63:0] M_WAIT = 64'h1 << 49;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tod_fire = 0, cpt_fire = 0, ext_push = 0;
    logic [15:0] ext_push_code = 0;
    logic [31:0] ext_push_parm = 0;
    logic        start = 0;
    logic [1:0]  exc_kind = 0;
    logic [15:0] exc_code = 0;
    logic [3:0]  exc_ilen = 0;
    logic [1:0]  cc_in = 0;
    logic        psw_wr = 0;
    logic [63:0] psw_wr_mask = 0, psw_wr_addr = 0;
    logic [63:0] psw_mask, psw_addr, mem_wdata, mem_rdata;
    logic [1:0]  cc_out, done_cls;
    logic        busy, done, halted, halt_req, ext_err, mem_valid, mem_we;
    logic [11:0] mem_addr;
    logic        mem_ready = 1'b1;
    logic [63:0] tbmem [64];

    always #2.5 clk = ~clk;

    intr_swapper dut (.*);

    always @(posedge clk) if (mem_valid && mem_ready && mem_we) tbmem[mem_addr[5:0]] <= mem_wdata;
    assign mem_rdata = tbmem[mem_addr[5:0]];

    // reference model state
    logic [63:0] e_mask = 0, e_addr = 0, m_nmask = 0;
    logic        e_busy = 0, e_done = 0, e_halted = 0, e_hreq = 0, e_err = 0;
    logic        tod_m = 0, cpt_m = 0;
    int          e_dcls = 0, m_cls = 0;
    logic [15:0] qc[$];
    logic [31:0] qp[$];
    logic [63:0] xa[$], xd[$];
    bit          xw[$];
    int          xk[$];
    string       xt[$];

    int n_chk = 0, n_bad = 0, cyc_n = 0;
    bit stall = 0, finished = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic add_xf(input bit we, input logic [63:0] a, input logic [63:0] d, input int k, input string t);
        xw.push_back(we); xa.push_back(a); xd.push_back(d); xk.push_back(k); xt.push_back(t);
    endtask

    task automatic model_next();
        bit ld = 0, take, popq = 0, ctod = 0, ccpt = 0, n_done = 0, n_hreq = 0, n_err = 0;
        int k, cls = 0, lvl;
        logic [63:0] a = 0, info = 0, om, oa, base = 0;
        string itag = "R2", atag = "R6";
        if (rst) begin
            e_mask = 0; e_addr = 0; e_busy = 0; e_done = 0; e_halted = 0; e_hreq = 0; e_err = 0;
            tod_m = 0; cpt_m = 0; qc.delete(); qp.delete();
            xw.delete(); xa.delete(); xd.delete(); xk.delete(); xt.delete();
            return;
        end
        if (e_busy && mem_ready) begin
            k = xk.pop_front(); a = xa.pop_front();
            void'(xw.pop_front()); void'(xd.pop_front()); void'(xt.pop_front());
            if (k == 1) m_nmask = tbmem[a[5:0]];
            if (k == 2) ld = 1;
        end
        take = start && !e_busy;
        if (take) begin
            om = e_mask; om[14:13] = cc_in; oa = e_addr;
            if (exc_kind == 2) begin
                cls = 2; info = {44'h0, exc_ilen, exc_code}; itag = "R6";
            end else if (exc_kind == 3) begin
                cls = 3; info = {44'h0, exc_ilen, exc_code}; oa = e_addr + 64'(exc_ilen);
                itag = "R5"; atag = "R5";
            end else if (e_mask[56]) begin
                if (qc.size() > 0) begin
                    cls = 1; info = {qp[$], 16'h0, qc[$]}; popq = 1; itag = "R2";
                end else if (tod_m) begin
                    cls = 1; info = {48'h0, 16'h1004}; ctod = 1; itag = "R3";
                end else if (cpt_m) begin
                    cls = 1; info = {48'h0, 16'h1005}; ctod = 1; ccpt = 1; itag = "R3";
                end
            end
            e_halted = 0;
            if (cls == 0) begin
                n_done = 1; e_dcls = 0;
            end else begin
                base = (cls == 1) ? 64'h10 : (cls == 2) ? 64'h30 : 64'h20;
                m_cls = cls; e_busy = 1;
                add_xf(1, base, info, 0, itag);
                add_xf(1, base + 1, om, 0, "R4");
                add_xf(1, base + 2, oa, 0, atag);
                add_xf(0, base + 3, 0, 1, "R9");
                add_xf(0, base + 4, 0, 2, "R9");
            end
        end
        if (ld) begin
            e_mask = m_nmask; e_addr = tbmem[a[5:0]]; e_busy = 0; n_done = 1; e_dcls = m_cls;
            e_halted = m_nmask[49];
            n_hreq = m_nmask[49] && !(m_nmask[57] || m_nmask[56] || m_nmask[50]);
        end else if (psw_wr && !e_busy && !take) begin
            e_mask = psw_wr_mask; e_addr = psw_wr_addr;
        end else if (psw_wr && take && cls == 0) begin
            e_mask = psw_wr_mask; e_addr = psw_wr_addr;
        end else if (psw_wr && take) begin
            e_mask = psw_wr_mask; e_addr = psw_wr_addr;
        end
        if (popq) begin void'(qc.pop_back()); void'(qp.pop_back()); end
        lvl = qc.size();
        if (ext_push) begin
            if (lvl < DEPTH) begin qc.push_back(ext_push_code); qp.push_back(ext_push_parm); end
            else n_err = 1;
        end
        if (ctod) tod_m = 0;
        if (ccpt) cpt_m = 0;
        if (tod_fire) tod_m = 1;
        if (cpt_fire) cpt_m = 1;
        e_done = n_done; e_hreq = n_hreq; e_err = n_err;
    endtask

    task automatic compare();
        chk("R10", "psw_mask", psw_mask, e_mask);
        chk("R11", "psw_addr", psw_addr, e_addr);
        chk("R4", "cc_out", 64'(cc_out), 64'(e_mask[14:13]));
        chk("R9", "busy", 64'(busy), 64'(e_busy));
        chk("R9", "mem_valid", 64'(mem_valid), 64'(e_busy));
        if (e_busy) begin
            chk("R9", "mem_we", 64'(mem_we), 64'(xw[0]));
            chk(xt[0], "mem_addr", 64'(mem_addr), xa[0]);
            if (xw[0]) chk(xt[0], "mem_wdata", mem_wdata, xd[0]);
        end
        chk("R10", "done", 64'(done), 64'(e_done));
        if (e_done) chk("R1", "done_cls", 64'(done_cls), 64'(e_dcls));
        chk("R8", "halted", 64'(halted), 64'(e_halted));
        chk("R8", "halt_req", 64'(halt_req), 64'(e_hreq));
        chk("R7", "ext_err", 64'(ext_err), 64'(e_err));
    endtask

    task automatic cyc();
        mem_ready = !(stall && (cyc_n % 3 == 1));
        model_next();
        @(posedge clk);
        cyc_n++;
        @(negedge clk);
        compare();
    endtask

    task automatic swap(input logic [1:0] kind, input logic [15:0] code, input logic [3:0] ilen, input bit wr_mid);
        start = 1; exc_kind = kind; exc_code = code; exc_ilen = ilen;
        cyc();
        start = 0; exc_kind = 0;
        if (wr_mid) begin   // R11: write attempt while busy
            psw_wr = 1; psw_wr_mask = 64'hFFFF; psw_wr_addr = 64'hDEAD;
            cyc();
            psw_wr = 0;
        end
        while (e_busy) cyc();
        cyc();
    endtask

    task automatic push(input logic [15:0] c, input logic [31:0] p);
        ext_push = 1; ext_push_code = c; ext_push_parm = p;
        cyc();
        ext_push = 0;
    endtask

    task automatic set_psw(input logic [63:0] m, input logic [63:0] a);
        psw_wr = 1; psw_wr_mask = m; psw_wr_addr = a;
        cyc();
        psw_wr = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) tbmem[i] = 64'h0;
        tbmem[6'h13] = M_EXT;                         tbmem[6'h14] = 64'h2000;
        tbmem[6'h33] = M_EXT | (64'h1 << 13);         tbmem[6'h34] = 64'h3000;
        tbmem[6'h23] = M_WAIT;                        tbmem[6'h24] = 64'h4000;
        @(negedge clk);
        repeat (3) cyc();                  // reset state
        rst = 0;
        cyc();
        cc_in = 2'd2;
        set_psw(M_EXT | (64'h3 << 13), 64'h1000);
        push(16'h0040, 32'hAAAA_0001);
        push(16'h0041, 32'hBBBB_0002);
        tod_fire = 1; cpt_fire = 1; cyc(); tod_fire = 0; cpt_fire = 0;
        swap(2, 16'h0011, 4'd4, 0);        // R1 R6: program wins over pending external
        swap(0, 0, 0, 0);                  // R2 R7: last pushed entry first
        stall = 1;
        swap(0, 0, 0, 0);                  // R9 under stalls
        stall = 0;
        swap(0, 0, 0, 0);                  // R3: time-of-day code
        swap(0, 0, 0, 0);                  // R3: cpu-timer code
        swap(0, 0, 0, 0);                  // R10: nothing to take
        set_psw(64'h0, 64'h5000);
        tod_fire = 1; cyc(); tod_fire = 0;
        swap(0, 0, 0, 0);                  // R1: external masked
        set_psw(M_EXT, 64'h5100);
        swap(0, 0, 0, 0);                  // R3: time-of-day now taken
        cc_in = 2'd1;
        stall = 1;
        swap(3, 16'h0022, 4'd2, 1);        // R5 R8 R11: svc into all-masked wait
        stall = 0;
        set_psw(M_EXT, 64'h6000);
        tbmem[6'h13] = M_EXT | M_WAIT;
        push(16'h0050, 32'h5);
        swap(0, 0, 0, 0);                  // R8: wait with external enabled
        swap(2, 16'h0007, 4'd6, 0);        // R8: start clears halted
        set_psw(M_EXT, 64'h7000);
        tbmem[6'h13] = M_EXT;
        for (int i = 0; i < 5; i++) push(16'h0060 + 16'(i), 32'(i)); // R7: fifth overruns
        ext_push = 1; ext_push_code = 16'h0077; ext_push_parm = 32'h77;
        start = 1; exc_kind = 0;
        cyc();                             // R7: pop and push in one cycle
        start = 0; ext_push = 0;
        while (e_busy) cyc();
        cyc();
        swap(0, 0, 0, 0);                  // R7: replacement entry on top
        repeat (3) cyc();
        summary();
    end

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end
endmodule